// File: doc/BRIEF.md
# ADC Output Word Formatter

This block turns each raw converter sample into the 14-bit word that leaves the chip. The sample arrives as a signed value wider than the 12 data bits. It is first clamped into the 12-bit range. It is then coded as offset binary or as two's complement. Two matching over-range flag bits are added on top. An LSB-keyed XOR scrambler can spread the data activity, and a programmed test word can replace the whole result. One register stage sits on the output, and a valid strobe marks each new word.

An output-enable state machine with two states controls whether the word port drives anything. In `ST_OFF` the port is quiet: the drive flag, word and strobe are all zero. In `ST_LIVE` the port carries formatted samples. The transition `EN_RISE` (`ST_OFF` to `ST_LIVE`) is taken when `cfg_out_en` is 1. The transition `EN_FALL` (`ST_LIVE` to `ST_OFF`) is taken when `cfg_out_en` is 0. In every other case the state stays where it is. Reset enters `ST_OFF`.

The same top also carries the receive-side unscrambler as a separate combinational path. A link partner or a loopback bench can use it to recover the coded word.

Top module: `adcfmt_tx`

## Requirements
- R1: With `cfg_twos`=0 the data field `out_word[11:0]` is offset binary, equal to the clamped value plus 2048. Input 0 gives 0x800, -1 gives 0x7FF, -2048 gives 0x000 and 2047 gives 0xFFF.
- R2: With `cfg_twos`=1 the data field is the clamped value in two's complement. This is the R1 code with bit 11 inverted: 0 gives 0x000, -1 gives 0xFFF, -2048 gives 0x800 and 2047 gives 0x7FF.
- R3: A raw input above 2047 is coded as 2047. A raw input at or below -2048 is coded as -2048.
- R4: Bits 12 and 13 of the word are both 1 when the raw input is above 2047. Otherwise both are 0, and that includes inputs below -2048.
- R5: With `cfg_rand`=1, each of bits 13..1 of the word is XORed with bit 0, and bit 0 is unchanged. This applies after coding and also covers bits 12 and 13.
- R6: The unscrambler output `dec_word_o` equals `dec_word_i` with bits 13..1 XORed with `dec_word_i[0]` when `dec_rand` is 1. When `dec_rand` is 0 it equals `dec_word_i` unchanged.
- R7: With `cfg_test_en`=1 the output word equals `cfg_test_pat` exactly, whatever the settings of `cfg_twos` and `cfg_rand`.
- R8: A sample accepted with `in_valid`=1 in state `ST_LIVE` appears on `out_word` one clock later, with `out_valid`=1 for that one cycle. When `in_valid` is 0, `out_valid` goes low and `out_word` holds its last value.
- R9: `out_drive` is 1 exactly when the state is `ST_LIVE`. In `ST_OFF`, after reset or from the edge after `cfg_out_en` falls, `out_word` is 0 and `out_valid` is 0, and any `in_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample present this cycle |
| in_sample | input | RAW_W (14) | Raw signed sample, wider than the data field |
| cfg_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| cfg_rand | input | 1 | Enables the LSB-keyed XOR scrambler |
| cfg_test_en | input | 1 | Replaces the word with the test pattern |
| cfg_test_pat | input | DATA_W+2 (14) | Programmed test word |
| cfg_out_en | input | 1 | Output enable, drives the state transitions |
| out_word | output | DATA_W+2 (14) | Registered word: bits 13 and 12 are the flags, bits 11..0 are the data |
| out_valid | output | 1 | New word on `out_word` |
| out_drive | output | 1 | Port is actively driven (`ST_LIVE`) |
| dec_word_i | input | DATA_W+2 (14) | Received word for unscrambling |
| dec_rand | input | 1 | Received word was scrambled |
| dec_word_o | output | DATA_W+2 (14) | Unscrambled word |

## Verification
The bench covers the code boundaries at 0, -1, -2048 and 2047, and a design whose offset is off by one would shift each of those by a single code. It drives inputs on both sides of the clamp, so a design that raised the flags on negative over-range, or that wrapped instead of clamping, would show a wrong top nibble. The scrambler is tried with odd and even LSBs, and with the flag bits set, and the result is passed back through the unscrambler. A design that skipped the flag bits or touched bit 0 would then fail the round trip. The test pattern is applied with scrambling and two's complement both enabled, and the enable is dropped while samples keep arriving, to expose a design that lets coding leak past the override or that keeps strobing while off.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
    // output-enable state of the word port
    typedef enum logic {
        ST_OFF  = 1'b0,
        ST_LIVE = 1'b1
    } adcfmt_state_e;

    // two over-range flag bits sit above the data field
    localparam int FLAG_BITS = 2;
endpackage

// File: rtl/adcfmt_clamp.sv
module adcfmt_clamp #(
    parameter int RAW_W  = 14,
    parameter int DATA_W = 12
) (
    input  logic signed [RAW_W-1:0]  raw_i,
    output logic        [DATA_W-1:0] twos_o,
    output logic                     ovr_pos_o
);
    localparam int POS_LIM = (2 ** (DATA_W - 1)) - 1;
    localparam int NEG_LIM = -(2 ** (DATA_W - 1));

    always_comb begin
        ovr_pos_o = 1'b0;
        if (int'(raw_i) > POS_LIM) begin
            ovr_pos_o = 1'b1;
            twos_o    = {1'b0, {(DATA_W-1){1'b1}}};
        end else if (int'(raw_i) < NEG_LIM) begin
            twos_o    = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            twos_o    = raw_i[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/adcfmt_xor_lsb.sv
module adcfmt_xor_lsb #(
    parameter int W = 14
) (
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic key;
    assign key       = en_i & din_i[0];
    assign dout_o[0] = din_i[0];

    for (genvar i = 1; i < W; i++) begin : g_bit
        assign dout_o[i] = din_i[i] ^ key;
    end
endmodule

// File: rtl/adcfmt_code.sv
module adcfmt_code #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0]                       twos_i,
    input  logic                                    ovr_pos_i,
    input  logic                                    twos_sel_i,
    input  logic                                    rand_en_i,
    output logic [DATA_W+adcfmt_pkg::FLAG_BITS-1:0] word_o
);
    localparam int W = DATA_W + adcfmt_pkg::FLAG_BITS;

    logic [DATA_W-1:0] data;
    logic [W-1:0]      plain;

    // offset binary is two's complement with the MSB flipped
    assign data  = twos_sel_i ? twos_i
                              : {~twos_i[DATA_W-1], twos_i[DATA_W-2:0]};
    assign plain = {ovr_pos_i, ovr_pos_i, data};

    adcfmt_xor_lsb #(.W(W)) u_scr (
        .en_i   (rand_en_i),
        .din_i  (plain),
        .dout_o (word_o)
    );

    // R4: both flag bits must always agree, scrambled or not
    always_comb begin
        a_r4_flag_pair: assert (word_o[W-1] == word_o[W-2])
            else $error("flag bits disagree");
    end
endmodule

// File: rtl/adcfmt_tx.sv
module adcfmt_tx #(
    parameter int RAW_W  = 14,
    parameter int DATA_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [RAW_W-1:0]        in_sample,
    input  logic                    cfg_twos,
    input  logic                    cfg_rand,
    input  logic                    cfg_test_en,
    input  logic [DATA_W+1:0]       cfg_test_pat,
    input  logic                    cfg_out_en,
    output logic [DATA_W+1:0]       out_word,
    output logic                    out_valid,
    output logic                    out_drive,
    input  logic [DATA_W+1:0]       dec_word_i,
    input  logic                    dec_rand,
    output logic [DATA_W+1:0]       dec_word_o
);
    import adcfmt_pkg::*;

    localparam int W = DATA_W + FLAG_BITS;

    adcfmt_state_e state_q, state_d;

    logic [DATA_W-1:0] clamped;
    logic              ovr_pos;
    logic [W-1:0]      coded;
    logic [W-1:0]      nxt_word;

    adcfmt_clamp #(.RAW_W(RAW_W), .DATA_W(DATA_W)) u_clamp (
        .raw_i     ($signed(in_sample)),
        .twos_o    (clamped),
        .ovr_pos_o (ovr_pos)
    );

    adcfmt_code #(.DATA_W(DATA_W)) u_code (
        .twos_i     (clamped),
        .ovr_pos_i  (ovr_pos),
        .twos_sel_i (cfg_twos),
        .rand_en_i  (cfg_rand),
        .word_o     (coded)
    );

    // the test word overrides coding and scrambling
    assign nxt_word = cfg_test_en ? cfg_test_pat : coded;

    // receive-side unscrambler: the same XOR applied a second time
    adcfmt_xor_lsb #(.W(W)) u_unscr (
        .en_i   (dec_rand),
        .din_i  (dec_word_i),
        .dout_o (dec_word_o)
    );

    // next-state logic: EN_RISE and EN_FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (cfg_out_en)  state_d = ST_LIVE;
            ST_LIVE: if (!cfg_out_en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output register, loaded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (state_d)
                ST_OFF: begin
                    out_word  <= '0;
                    out_valid <= 1'b0;
                end
                ST_LIVE: begin
                    out_valid <= in_valid;
                    if (in_valid) out_word <= nxt_word;
                end
                default: begin
                    out_word  <= '0;
                    out_valid <= 1'b0;
                end
            endcase
        end
    end

    assign out_drive = (state_q == ST_LIVE);

    // R9: an undriven port stays quiet
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_drive |-> (out_word == '0 && !out_valid));

    // R9: the port starts driving only after the enable was seen
    a_r9_drive_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_drive) |-> $past(cfg_out_en));

    // R8: a strobe needs an accepted sample one cycle earlier
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && cfg_out_en));

    // R7: the test word arrives untouched
    a_r7_test_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_test_en)) |-> out_word == $past(cfg_test_pat));
endmodule

// File: tb/adcfmt_tx_tb.sv
module adcfmt_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic        cfg_twos = 1'b0, cfg_rand = 1'b0, cfg_test_en = 1'b0;
    logic [13:0] cfg_test_pat = '0;
    logic        cfg_out_en = 1'b0;
    logic [13:0] out_word;
    logic        out_valid, out_drive;
    logic [13:0] dec_word_i;
    logic        dec_rand = 1'b0;
    logic [13:0] dec_word_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign dec_word_i = out_word;   // loopback into the unscrambler

    adcfmt_tx u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_twos(cfg_twos), .cfg_rand(cfg_rand), .cfg_test_en(cfg_test_en),
        .cfg_test_pat(cfg_test_pat), .cfg_out_en(cfg_out_en),
        .out_word(out_word), .out_valid(out_valid), .out_drive(out_drive),
        .dec_word_i(dec_word_i), .dec_rand(dec_rand), .dec_word_o(dec_word_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // expected word from the requirements
    function automatic logic [13:0] model(int raw, bit twos, bit rnd);
        int          c;
        logic        ovr;
        logic [11:0] d;
        logic [13:0] w;
        ovr = (raw > 2047);
        c   = (raw > 2047) ? 2047 : ((raw < -2048) ? -2048 : raw);
        d   = twos ? 12'(c) : 12'(c + 2048);
        w   = {ovr, ovr, d};
        if (rnd && w[0]) w = w ^ 14'h3FFE;
        return w;
    endfunction

    task automatic set_cfg(bit twos, bit rnd, bit tst, logic [13:0] pat, bit en);
        @(negedge clk);
        cfg_twos = twos; cfg_rand = rnd; cfg_test_en = tst;
        cfg_test_pat = pat; cfg_out_en = en; dec_rand = rnd;
    endtask

    task automatic send(int raw);
        @(negedge clk);
        in_sample = 14'(raw);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset drive", 32'(out_drive), 0);
        check("R9 reset word", 32'(out_word), 0);
        check("R9 reset valid", 32'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        set_cfg(0, 0, 0, '0, 1);
        @(negedge clk);
        check("R9 drive after enable", 32'(out_drive), 1);
    endtask

    task automatic t_offset;
        int vals[6] = '{0, -1, -2048, 2047, 1, -2047};
        set_cfg(0, 0, 0, '0, 1);
        send(0);
        check("R1 zero", 32'(out_word), 32'h0800);
        send(-1);
        check("R1 minus one", 32'(out_word), 32'h07FF);
        foreach (vals[i]) begin
            send(vals[i]);
            check("R1 offset", 32'(out_word), 32'(model(vals[i], 0, 0)));
        end
    endtask

    task automatic t_twos;
        int vals[5] = '{0, -1, -2048, 2047, 5};
        set_cfg(1, 0, 0, '0, 1);
        send(-1);
        check("R2 minus one", 32'(out_word), 32'h0FFF);
        send(-2048);
        check("R2 min", 32'(out_word), 32'h0800);
        foreach (vals[i]) begin
            send(vals[i]);
            check("R2 twos", 32'(out_word), 32'(model(vals[i], 1, 0)));
        end
    endtask

    task automatic t_clamp;
        set_cfg(0, 0, 0, '0, 1);
        send(5000);
        check("R3 R4 pos clamp", 32'(out_word), 32'h3FFF);
        send(2048);
        check("R3 R4 just over", 32'(out_word), 32'h3FFF);
        send(-5000);
        check("R3 R4 neg clamp", 32'(out_word), 32'h0000);
        send(-2049);
        check("R3 R4 just under", 32'(out_word), 32'h0000);
        set_cfg(1, 0, 0, '0, 1);
        send(3000);
        check("R3 R4 twos pos", 32'(out_word), 32'h37FF);
        send(-8000);
        check("R3 R4 twos neg", 32'(out_word), 32'h0800);
    endtask

    task automatic t_rand;
        set_cfg(0, 1, 0, '0, 1);
        send(1);
        check("R5 odd lsb", 32'(out_word), 32'h37FF);
        check("R6 odd lsb", 32'(dec_word_o), 32'h0801);
        send(2);
        check("R5 even lsb", 32'(out_word), 32'h0802);
        send(6000);
        check("R5 flags odd", 32'(out_word), 32'h0001);
        check("R6 flags odd", 32'(dec_word_o), 32'h3FFF);
        @(negedge clk);
        dec_rand = 1'b0;
        #1;
        check("R6 passthrough", 32'(dec_word_o), 32'h0001);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            bit twos = 1'($urandom);
            bit rnd  = 1'($urandom);
            int raw  = int'($urandom_range(0, 6000)) - 3000;
            set_cfg(twos, rnd, 0, '0, 1);
            send(raw);
            check("R1 R2 R5 random", 32'(out_word), 32'(model(raw, twos, rnd)));
            check("R6 round trip", 32'(dec_word_o), 32'(model(raw, twos, 0)));
        end
    endtask

    task automatic t_test;
        set_cfg(1, 1, 1, 14'h2A5B, 1);
        send(5000);
        check("R7 pattern", 32'(out_word), 32'h2A5B);
        set_cfg(0, 1, 1, 14'h1235, 1);
        send(-7);
        check("R7 odd pattern", 32'(out_word), 32'h1235);
        set_cfg(0, 0, 0, '0, 1);
    endtask

    task automatic t_latency;
        set_cfg(0, 0, 0, '0, 1);
        @(negedge clk);
        in_sample = 14'(100);
        in_valid  = 1'b1;
        #1;
        check("R8 not yet", 32'(out_valid), 0);
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = 14'(-300);
        check("R8 strobe", 32'(out_valid), 1);
        check("R8 word", 32'(out_word), 32'(model(100, 0, 0)));
        @(negedge clk);
        check("R8 strobe drop", 32'(out_valid), 0);
        check("R8 hold", 32'(out_word), 32'(model(100, 0, 0)));
    endtask

    task automatic t_disable;
        set_cfg(0, 0, 0, '0, 0);
        send(300);
        check("R9 off drive", 32'(out_drive), 0);
        check("R9 off word", 32'(out_word), 0);
        check("R9 off valid", 32'(out_valid), 0);
        set_cfg(0, 0, 0, '0, 1);
        @(negedge clk);
        check("R9 re-enable drive", 32'(out_drive), 1);
        check("R9 re-enable word", 32'(out_word), 0);
    endtask

    initial begin
        t_reset();
        t_offset();
        t_twos();
        t_clamp();
        t_rand();
        t_random();
        t_test();
        t_latency();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule